// File: doc/BRIEF.md
# Cartridge Bank-Switching Mapper

This block sits between an 8-bit console's CPU and PPU buses and the ROMs of a cartridge. It breaks a 128 kB program ROM into 8 kB windows and a 256 kB character ROM into 2 kB and 1 kB windows. The CPU selects banks by writing into the upper half of its address space. The mapper also drives the address line of the console's nametable RAM, which sets vertical or horizontal mirroring.

Writes are seen through the cartridge bus qualifiers. The ROM select input is active low and the read/write input is low for writes. A write is taken when M2 falls while both qualifiers show a cartridge write. The block works in a fast system clock domain: it registers M2 and turns each falling edge into a single write strobe. All address translation is combinational, so a new bank value appears on the ROM address outputs one clock after the M2 fall is seen.

Top module: `cart_bank_mapper`

## Requirements
- R1: After reset every bank register holds 0 and mirroring is vertical. The $8000 window then maps to PRG address 0 and every CHR window maps to bank 0.
- R2: Registers decode only on CPU A14, A13, A1 and A0. Each register therefore repeats across its whole 8 kB window; for example, $9FFC acts as $8000 and $FFFC acts as $E000.
- R3: Writes to $8000 and $8001 store data[3:0] as the bank for CPU $8000-$9FFF and $A000-$BFFF. In those windows prg_addr_o = {bank, A12..A0}. Data bits 7:4 are ignored.
- R4: CPU $C000-$DFFF always maps to PRG bank 14 and $E000-$FFFF to bank 15: prg_addr_o = {3'b111, A13..A0}.
- R5: Writes to $8002 and $8003 store data[6:0] as the 2 kB CHR bank for PPU $0000-$07FF and $0800-$0FFF. When PPU A12 = 0, chr_addr_o = {value, PPU A10..A0}, and bit 0 of the value lands on chr_addr_o[11].
- R6: Writes to $A000..$A003 store data[7:0] as the 1 kB CHR bank for PPU $1000, $1400, $1800 and $1C00. When PPU A12 = 1, chr_addr_o = {value, PPU A9..A0}.
- R7: A write to $E000 stores data bit 6 as the mirroring flag. With 0, ciram_a10_o follows PPU A10; with 1, it follows PPU A11. Writes to $E001..$E003 change nothing.
- R8: A register takes a write only when romsel_ni = 0 and cpu_rw_i = 0 at the M2 falling edge. It takes the data present at that edge, and only once per M2 low phase.
- R9: prg_ce_no is low only while romsel_ni = 0 and cpu_rw_i = 1.
- R10: Writes to $C000-$DFFF change no output mapping.
- R11: A written value appears on the outputs after the first clock edge that sees M2 low following M2 high. Before that edge the old value holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock, faster than M2 |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cpu_addr_i | input | 16 | CPU address bus |
| cpu_data_i | input | 8 | CPU data bus |
| cpu_rw_i | input | 1 | CPU read (1) / write (0) |
| romsel_ni | input | 1 | Cartridge ROM select, active low |
| m2_i | input | 1 | CPU bus phase clock |
| ppu_addr_i | input | 14 | PPU address bus |
| prg_addr_o | output | 17 | Program ROM address |
| prg_ce_no | output | 1 | Program ROM chip enable, active low |
| chr_addr_o | output | 18 | Character ROM address |
| ciram_a10_o | output | 1 | Nametable RAM A10 |

## Verification
The register write path and the address translation can fall in the same clock: a CPU write to a bank register can land while the PPU or CPU is fetching through that very bank. The bench holds the CPU address on the register being written, which is also a read window. It then samples prg_addr_o just before and just after the clock edge that sees M2 fall. The old bank must hold before that edge and the new bank must show after it. Changing the data while M2 stays low shows that the strobe fires only once in a low phase.

// File: rtl/mapper_pkg.sv
package mapper_pkg;
  parameter int CPU_AW     = 16;
  parameter int CPU_DW     = 8;
  parameter int PPU_AW     = 14;
  parameter int PRG_BANK_W = 4;
  parameter int CHR2K_W    = 7;
  parameter int CHR1K_W    = 8;
  parameter int PRG_SLOTS  = 2;
  parameter int CHR2K_SLOTS = 2;
  parameter int CHR1K_SLOTS = 4;
  parameter int MIRROR_BIT = 6;

  localparam int PRG_AW = PRG_BANK_W + 13;
  localparam int CHR_AW = CHR2K_W + 11;

  typedef logic [PRG_BANK_W-1:0] prg_bank_t;
  typedef logic [CHR2K_W-1:0]    chr2k_bank_t;
  typedef logic [CHR1K_W-1:0]    chr1k_bank_t;

  // register group from CPU A14:A13
  typedef enum logic [1:0] {
    GRP_LOW  = 2'b00,
    GRP_CHR1 = 2'b01,
    GRP_NONE = 2'b10,
    GRP_TOP  = 2'b11
  } reg_grp_e;
endpackage

// File: rtl/mapper_regs.sv
module mapper_regs
  import mapper_pkg::*;
(
  input  logic                                clk_i,
  input  logic                                rst_ni,
  input  logic [CPU_AW-1:0]                   cpu_addr_i,
  input  logic [CPU_DW-1:0]                   cpu_data_i,
  input  logic                                cpu_rw_i,
  input  logic                                romsel_ni,
  input  logic                                m2_i,
  output logic                                wr_en_o,
  output logic [PRG_SLOTS-1:0][PRG_BANK_W-1:0] prg_bank_o,
  output logic [CHR2K_SLOTS-1:0][CHR2K_W-1:0]  chr2k_o,
  output logic [CHR1K_SLOTS-1:0][CHR1K_W-1:0]  chr1k_o,
  output logic                                mirror_h_o
);
  logic     m2_q;
  reg_grp_e grp;
  logic [1:0] idx;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) m2_q <= 1'b0;
    else         m2_q <= m2_i;
  end

  // one strobe per M2 falling edge
  assign wr_en_o = m2_q & ~m2_i & ~romsel_ni & ~cpu_rw_i;
  assign grp     = reg_grp_e'(cpu_addr_i[14:13]);
  assign idx     = cpu_addr_i[1:0];

  for (genvar i = 0; i < PRG_SLOTS; i++) begin : g_prg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)
        prg_bank_o[i] <= '0;
      else if (wr_en_o && grp == GRP_LOW && idx == 2'(i))
        prg_bank_o[i] <= cpu_data_i[PRG_BANK_W-1:0];
    end
  end

  for (genvar i = 0; i < CHR2K_SLOTS; i++) begin : g_chr2k
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)
        chr2k_o[i] <= '0;
      else if (wr_en_o && grp == GRP_LOW && idx == 2'(i + PRG_SLOTS))
        chr2k_o[i] <= cpu_data_i[CHR2K_W-1:0];
    end
  end

  for (genvar i = 0; i < CHR1K_SLOTS; i++) begin : g_chr1k
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)
        chr1k_o[i] <= '0;
      else if (wr_en_o && grp == GRP_CHR1 && idx == 2'(i))
        chr1k_o[i] <= cpu_data_i[CHR1K_W-1:0];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)
      mirror_h_o <= 1'b0;
    else if (wr_en_o && grp == GRP_TOP && idx == 2'd0)
      mirror_h_o <= cpu_data_i[MIRROR_BIT];
  end
endmodule

// File: rtl/mapper_prg.sv
module mapper_prg
  import mapper_pkg::*;
(
  input  logic [CPU_AW-1:0]                    cpu_addr_i,
  input  logic                                 cpu_rw_i,
  input  logic                                 romsel_ni,
  input  logic [PRG_SLOTS-1:0][PRG_BANK_W-1:0] prg_bank_i,
  output logic [PRG_AW-1:0]                    prg_addr_o,
  output logic                                 prg_ce_no
);
  prg_bank_t bank;

  always_comb begin
    if (cpu_addr_i[14])
      bank = {{(PRG_BANK_W-1){1'b1}}, cpu_addr_i[13]};  // fixed last two banks
    else
      bank = prg_bank_i[cpu_addr_i[13]];
  end

  assign prg_addr_o = {bank, cpu_addr_i[12:0]};
  assign prg_ce_no  = romsel_ni | ~cpu_rw_i;
endmodule

// File: rtl/mapper_chr.sv
module mapper_chr
  import mapper_pkg::*;
(
  input  logic [PPU_AW-1:0]                   ppu_addr_i,
  input  logic [CHR2K_SLOTS-1:0][CHR2K_W-1:0] chr2k_i,
  input  logic [CHR1K_SLOTS-1:0][CHR1K_W-1:0] chr1k_i,
  input  logic                                mirror_h_i,
  output logic [CHR_AW-1:0]                   chr_addr_o,
  output logic                                ciram_a10_o
);
  logic [CHR_AW-1:0] addr_2k, addr_1k;

  assign addr_2k = CHR_AW'({chr2k_i[ppu_addr_i[11]], ppu_addr_i[10:0]});
  assign addr_1k = CHR_AW'({chr1k_i[ppu_addr_i[11:10]], ppu_addr_i[9:0]});

  assign chr_addr_o  = ppu_addr_i[12] ? addr_1k : addr_2k;
  assign ciram_a10_o = mirror_h_i ? ppu_addr_i[11] : ppu_addr_i[10];
endmodule

// File: rtl/cart_bank_mapper.sv
module cart_bank_mapper
  import mapper_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [15:0]        cpu_addr_i,
  input  logic [7:0]         cpu_data_i,
  input  logic               cpu_rw_i,
  input  logic               romsel_ni,
  input  logic               m2_i,
  input  logic [13:0]        ppu_addr_i,
  output logic [16:0]        prg_addr_o,
  output logic               prg_ce_no,
  output logic [17:0]        chr_addr_o,
  output logic               ciram_a10_o
);
  logic                                 wr_en;
  logic                                 mirror_h;
  logic [PRG_SLOTS-1:0][PRG_BANK_W-1:0] prg_bank;
  logic [CHR2K_SLOTS-1:0][CHR2K_W-1:0]  chr2k;
  logic [CHR1K_SLOTS-1:0][CHR1K_W-1:0]  chr1k;

  mapper_regs u_regs (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .cpu_addr_i (cpu_addr_i),
    .cpu_data_i (cpu_data_i),
    .cpu_rw_i   (cpu_rw_i),
    .romsel_ni  (romsel_ni),
    .m2_i       (m2_i),
    .wr_en_o    (wr_en),
    .prg_bank_o (prg_bank),
    .chr2k_o    (chr2k),
    .chr1k_o    (chr1k),
    .mirror_h_o (mirror_h)
  );

  mapper_prg u_prg (
    .cpu_addr_i (cpu_addr_i),
    .cpu_rw_i   (cpu_rw_i),
    .romsel_ni  (romsel_ni),
    .prg_bank_i (prg_bank),
    .prg_addr_o (prg_addr_o),
    .prg_ce_no  (prg_ce_no)
  );

  mapper_chr u_chr (
    .ppu_addr_i  (ppu_addr_i),
    .chr2k_i     (chr2k),
    .chr1k_i     (chr1k),
    .mirror_h_i  (mirror_h),
    .chr_addr_o  (chr_addr_o),
    .ciram_a10_o (ciram_a10_o)
  );
endmodule

// File: rtl/mapper_checks.sv
module mapper_checks (
  input logic        clk_i,
  input logic        rst_ni,
  input logic [15:0] cpu_addr_i,
  input logic        cpu_rw_i,
  input logic        romsel_ni,
  input logic [13:0] ppu_addr_i,
  input logic [16:0] prg_addr_o,
  input logic        prg_ce_no,
  input logic [17:0] chr_addr_o,
  input logic        ciram_a10_o,
  input logic        wr_en,
  input logic        mirror_h
);
  AST_CE_NOT_ON_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cpu_rw_i |-> prg_ce_no); // R9
  AST_CE_NEEDS_ROMSEL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    romsel_ni |-> prg_ce_no); // R9
  AST_FIXED_TOP_BANKS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cpu_addr_i[14] |-> prg_addr_o[16:13] == {3'b111, cpu_addr_i[13]}); // R4
  AST_PRG_OFFSET_PASS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    prg_addr_o[12:0] == cpu_addr_i[12:0]); // R3
  AST_CHR2K_OFFSET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ppu_addr_i[12] |-> chr_addr_o[10:0] == ppu_addr_i[10:0]); // R5
  AST_CHR1K_OFFSET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ppu_addr_i[12] |-> chr_addr_o[9:0] == ppu_addr_i[9:0]); // R6
  AST_MIRROR_VERT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mirror_h |-> ciram_a10_o == ppu_addr_i[10]); // R7
  AST_MIRROR_HORZ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mirror_h |-> ciram_a10_o == ppu_addr_i[11]); // R7
  AST_MIRROR_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_en |=> $stable(mirror_h)); // R8
endmodule

bind cart_bank_mapper mapper_checks u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .cpu_addr_i  (cpu_addr_i),
  .cpu_rw_i    (cpu_rw_i),
  .romsel_ni   (romsel_ni),
  .ppu_addr_i  (ppu_addr_i),
  .prg_addr_o  (prg_addr_o),
  .prg_ce_no   (prg_ce_no),
  .chr_addr_o  (chr_addr_o),
  .ciram_a10_o (ciram_a10_o),
  .wr_en       (wr_en),
  .mirror_h    (mirror_h)
);

// File: tb/sim_cart_bank_mapper.sv
`timescale 1ns/1ps
module sim_cart_bank_mapper;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] cpu_addr = 16'h0000;
  logic [7:0]  cpu_data = 8'h00;
  logic        cpu_rw = 1'b1;
  logic        romsel_n = 1'b1;
  logic        m2 = 1'b0;
  logic [13:0] ppu_addr = 14'h0000;
  logic [16:0] prg_addr;
  logic        prg_ce_n;
  logic [17:0] chr_addr;
  logic        ciram_a10;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  cart_bank_mapper u0 (
    .clk_i(clk), .rst_ni(rst_n), .cpu_addr_i(cpu_addr), .cpu_data_i(cpu_data),
    .cpu_rw_i(cpu_rw), .romsel_ni(romsel_n), .m2_i(m2), .ppu_addr_i(ppu_addr),
    .prg_addr_o(prg_addr), .prg_ce_no(prg_ce_n), .chr_addr_o(chr_addr),
    .ciram_a10_o(ciram_a10)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic cpu_write(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk);
    cpu_addr = a; cpu_data = d; cpu_rw = 1'b0; romsel_n = 1'b0; m2 = 1'b1;
    @(negedge clk);
    @(negedge clk);
    m2 = 1'b0;
    @(negedge clk);
    romsel_n = 1'b1; cpu_rw = 1'b1;
    @(negedge clk);
  endtask

  task automatic prg_probe(input string req, input logic [15:0] a, input logic [16:0] exp);
    cpu_addr = a; cpu_rw = 1'b1; romsel_n = 1'b0;
    #1 check(req, 32'(prg_addr), 32'(exp));
    romsel_n = 1'b1;
  endtask

  task automatic chr_probe(input string req, input logic [13:0] a, input logic [17:0] exp);
    ppu_addr = a;
    #1 check(req, 32'(chr_addr), 32'(exp));
  endtask

  task automatic nt_probe(input string req, input logic [13:0] a, input logic exp);
    ppu_addr = a;
    #1 check(req, 32'(ciram_a10), 32'(exp));
  endtask

  task automatic finish_run;
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      finish_run();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    prg_probe("R1", 16'h8000, 17'h0);
    prg_probe("R1", 16'hA010, 17'h10);
    chr_probe("R1", 14'h0000, 18'h0);
    chr_probe("R1", 14'h1C05, 18'h5);
    nt_probe("R1", 14'h0400, 1'b1);
    nt_probe("R1", 14'h0800, 1'b0);

    // R9 chip enable
    cpu_addr = 16'h8000; cpu_rw = 1'b1; romsel_n = 1'b0;
    #1 check("R9", 32'(prg_ce_n), 0);
    cpu_rw = 1'b0;
    #1 check("R9", 32'(prg_ce_n), 1);
    cpu_rw = 1'b1; romsel_n = 1'b1;
    #1 check("R9", 32'(prg_ce_n), 1);

    // R3 PRG banks, upper data bits ignored
    for (int b = 0; b < 16; b++) begin
      cpu_write(16'h8000, 8'(8'hF0 | b));
      cpu_write(16'h8001, 8'(15 - b));
      prg_probe("R3", 16'(16'h8000 + b * 16'h1F3), 17'({4'(b), 13'(b * 16'h1F3)}));
      prg_probe("R3", 16'(16'hA000 + b * 16'h1F3), 17'({4'(15 - b), 13'(b * 16'h1F3)}));
    end

    // R4 fixed top banks
    for (int k = 0; k < 24; k++) begin
      logic [15:0] a;
      a = 16'(16'hC000 + k * 16'h2A7);
      prg_probe("R4", a, 17'({3'b111, a[13:0]}));
    end

    // R5 2 kB CHR banks, low bit kept
    for (int v = 0; v < 128; v++) begin
      cpu_write(16'h8002, 8'(v));
      cpu_write(16'h8003, 8'(127 - v));
      chr_probe("R5", 14'h0401, 18'({7'(v), 11'h401}));
      chr_probe("R5", 14'h0BFE, 18'({7'(127 - v), 11'h3FE}));
    end

    // R6 1 kB CHR banks
    for (int v = 0; v < 256; v += 17) begin
      for (int k = 0; k < 4; k++) cpu_write(16'(16'hA000 + k), 8'(v + 3 * k));
      for (int k = 0; k < 4; k++)
        chr_probe("R6", 14'(14'h1000 + k * 14'h400 + 14'h155), 18'({8'(v + 3 * k), 10'h155}));
    end

    // R2 mirrored register addresses
    cpu_write(16'h9FFC, 8'h07);
    prg_probe("R2", 16'h8000, 17'({4'h7, 13'h0}));
    cpu_write(16'h9FF9, 8'h0A);
    prg_probe("R2", 16'hA000, 17'({4'hA, 13'h0}));
    cpu_write(16'hBFFF, 8'h5C);
    chr_probe("R2", 14'h1C00, 18'({8'h5C, 10'h0}));
    cpu_write(16'hFFFC, 8'h40);
    nt_probe("R2", 14'h0800, 1'b1);

    // R7 mirroring
    cpu_write(16'hE000, 8'hBF);
    nt_probe("R7", 14'h2400, 1'b1);
    nt_probe("R7", 14'h2800, 1'b0);
    cpu_write(16'hE000, 8'h40);
    nt_probe("R7", 14'h2400, 1'b0);
    nt_probe("R7", 14'h2800, 1'b1);
    cpu_write(16'hE001, 8'h00);
    cpu_write(16'hE002, 8'h00);
    cpu_write(16'hE003, 8'h00);
    nt_probe("R7", 14'h2C00, 1'b1);
    cpu_write(16'hE000, 8'h00);
    nt_probe("R7", 14'h2C00, 1'b1);
    nt_probe("R7", 14'h2800, 1'b0);

    // R8 qualifiers: set known state first
    cpu_write(16'h8000, 8'h03);
    @(negedge clk);
    cpu_addr = 16'h8000; cpu_data = 8'h05; cpu_rw = 1'b1; romsel_n = 1'b0; m2 = 1'b1;
    repeat (2) @(negedge clk);
    m2 = 1'b0;
    repeat (2) @(negedge clk);
    romsel_n = 1'b1;
    prg_probe("R8", 16'h8000, 17'({4'h3, 13'h0}));
    @(negedge clk);
    cpu_data = 8'h06; cpu_rw = 1'b0; romsel_n = 1'b1; m2 = 1'b1;
    repeat (2) @(negedge clk);
    m2 = 1'b0;
    repeat (2) @(negedge clk);
    cpu_rw = 1'b1;
    prg_probe("R8", 16'h8000, 17'({4'h3, 13'h0}));
    // once per M2 low phase, data at the fall edge
    @(negedge clk);
    cpu_data = 8'h09; cpu_rw = 1'b0; romsel_n = 1'b0; m2 = 1'b1;
    repeat (2) @(negedge clk);
    m2 = 1'b0;
    @(negedge clk);
    cpu_data = 8'h0C;
    repeat (4) @(negedge clk);
    cpu_rw = 1'b1;
    prg_probe("R8", 16'h8000, 17'({4'h9, 13'h0}));

    // R11 update timing, write and translation in the same window
    @(negedge clk);
    cpu_addr = 16'h8004; cpu_data = 8'h0B; cpu_rw = 1'b0; romsel_n = 1'b0; m2 = 1'b1;
    repeat (2) @(negedge clk);
    m2 = 1'b0;
    #1 check("R11", 32'(prg_addr), 32'({4'h9, 13'h4}));
    @(negedge clk);
    #1 check("R11", 32'(prg_addr), 32'({4'hB, 13'h4}));
    cpu_rw = 1'b1; romsel_n = 1'b1;
    @(negedge clk);

    // R10 writes to $C000-$DFFF ignored
    cpu_write(16'h8001, 8'h02);
    cpu_write(16'h8002, 8'h11);
    cpu_write(16'hA001, 8'h22);
    for (int k = 0; k < 4; k++) cpu_write(16'(16'hC000 + k), 8'hFF);
    cpu_write(16'hDFFE, 8'hFF);
    prg_probe("R10", 16'h8000, 17'({4'hB, 13'h0}));
    prg_probe("R10", 16'hA000, 17'({4'h2, 13'h0}));
    chr_probe("R10", 14'h0000, 18'({7'h11, 11'h0}));
    chr_probe("R10", 14'h1400, 18'({8'h22, 10'h0}));
    nt_probe("R10", 14'h0400, 1'b1);
    nt_probe("R10", 14'h0800, 1'b0);

    finish_run();
  end
endmodule